// File: doc/BRIEF.md
# Parallel LCD Bus Master

This block sits on the host side of a character or graphic LCD controller and runs its parallel bus: register select, read/write select, an enable strobe and eight data lines. A client issues one-byte commands through a valid/ready port. Each command is an instruction write, a data write, a data read or a status read. For every command the block first reads the controller status, repeating until the busy bit reads clear. It then performs the transfer itself. When the transfer is a read, it returns the byte together with the 7-bit address counter that came back in the last idle status read.

A static `nibble_mode` input selects 4-bit operation. In 4-bit mode each byte, including every status byte, moves in two enable strobes on the upper four data lines, upper half first. All enable timing comes from the clock frequency parameter and from nanosecond limits, each rounded up to whole cycles. A programmable poll limit bounds how long the block waits on a busy controller. When the limit is exceeded, the command is dropped and an error pulse is raised. The data lines are split into an output, an output enable and an input, so the pad ring can build the tri-state buffer.

Top module: `lcd_pbus_master`

## Requirements
- R1: While and directly after reset: `lcd_e`, `lcd_rs`, `lcd_rw`, `db_oe`, `rsp_valid` and `poll_err` are 0, and `cmd_ready` is 1.
- R2: Before the transfer of an accepted command, the block performs status reads (RS=0, RW=1). It repeats them while the status byte has bit 7 (busy) set. The transfer strobe follows only after a status read returns bit 7 = 0.
- R3: The transfer strobe carries the command's select bits: RS=0/RW=0 is an instruction write, RS=1/RW=0 a data write, RS=1/RW=1 a data read and RS=0/RW=1 a status read.
- R4: With `nibble_mode`=0, each byte, including each status byte, takes exactly one enable strobe. A written byte appears whole on `db_o[7:0]`.
- R5: With `nibble_mode`=1, each byte takes two strobes. On a write, `db_o[7:4]` carries bits 7..4 first and bits 3..0 second, and `db_o[3:0]` is 0. On a read, the byte is assembled from `db_i[7:4]` of the first strobe (upper half) and of the second strobe (lower half). `db_i[3:0]` is ignored, and the busy bit is taken from the first strobe.
- R6: `db_oe` is never 1 while `lcd_rw` is 1. During a write strobe `db_oe` is 1 from setup through hold.
- R7: Enable high time is max(pulse width, read delay + one cycle, data setup) rounded up (7 cycles at 50 MHz). Rising edges are at least the enable cycle time apart (60 cycles at 50 MHz). RS, RW and the write data are stable from one cycle before the rising edge until one cycle after the falling edge.
- R8: A read command ends with a one-cycle `rsp_valid`. It carries the read byte on `rsp_data` and, on `rsp_addr`, status bits 6..0 from the final idle status read of that command. Write commands produce no `rsp_valid`.
- R9: With a limit L on `poll_limit`, L busy status reads are tolerated. The (L+1)-th consecutive busy read ends the command with a one-cycle `poll_err`, no transfer strobe and no `rsp_valid`. `poll_err` and `rsp_valid` are never high together.
- R10: `cmd_ready` is 1 only when no command is in progress, and then `lcd_e` is 0. A command is accepted on the cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 in the following cycle and returns to 1 in the same cycle as `rsp_valid` or `poll_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nibble_mode | input | 1 | 1 = 4-bit bus, 0 = 8-bit bus; change only while idle |
| poll_limit | input | LIMIT_W | Busy status reads tolerated before a command is abandoned |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_rs | input | 1 | Register select of the command |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read completion |
| rsp_data | output | 8 | Byte read |
| rsp_addr | output | 7 | Address counter from the last idle status read |
| poll_err | output | 1 | One-cycle busy-timeout indication |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus read/write select |
| lcd_e | output | 1 | Bus enable strobe |
| db_o | output | 8 | Data lines driven toward the controller |
| db_oe | output | 1 | Output enable for `db_o` |
| db_i | input | 8 | Data lines from the controller |

## Verification
Two events share one cycle here. The read response (or the timeout pulse) fires on the same clock edge where the command port turns ready again. The bench captures the pulses in a per-clock monitor, apart from the task that waits for ready, so a pulse that lands exactly on the ready edge is still checked against the expected byte and address. A busy controller model also places the idle status read right before the transfer. In 4-bit mode the busy verdict must wait for the second nibble strobe, and the bench judges that the pair is never split by comparing the full strobe sequence with one built from the requirements.

// File: rtl/lcd_pbus_pkg.sv
package lcd_pbus_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_POLL = 2'd1,
        SQ_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] data;
    } lcd_req_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns_to_cycles(input int ns, input int clk_khz);
        longint prod;
        prod = longint'(ns) * longint'(clk_khz);
        return int'((prod + 64'sd999_999) / 64'sd1_000_000);
    endfunction

    // Enable-high cycles: pulse width, read access plus one sampling cycle,
    // and data setup before the falling edge (minus the setup cycles).
    function automatic int strobe_hi_cycles(input int pw_ns, input int ddr_ns,
                                            input int dsw_ns, input int su_cyc,
                                            input int clk_khz);
        int hi;
        hi = max_i(ns_to_cycles(pw_ns, clk_khz), ns_to_cycles(ddr_ns, clk_khz) + 1);
        hi = max_i(hi, ns_to_cycles(dsw_ns, clk_khz) - su_cyc);
        return max_i(hi, 1);
    endfunction

endpackage

// File: rtl/lcd_pbus_strobe.sv
module lcd_pbus_strobe
    import lcd_pbus_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int T_CYC_NS  = 1200,
    parameter int T_PW_NS   = 140,
    parameter int T_SU_NS   = 10,
    parameter int T_HOLD_NS = 20,
    parameter int T_DSW_NS  = 40,
    parameter int T_DDR_NS  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  lcd_req_t   req,
    output logic       done,
    output logic [7:0] rdata,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] db_o,
    output logic       db_oe,
    input  logic [7:0] db_i
);
    localparam int N_SU   = max_i(1, ns_to_cycles(T_SU_NS, CLK_KHZ));
    localparam int N_HI   = strobe_hi_cycles(T_PW_NS, T_DDR_NS, T_DSW_NS, N_SU, CLK_KHZ);
    localparam int N_HOLD = max_i(1, ns_to_cycles(T_HOLD_NS, CLK_KHZ));
    localparam int N_TOT  = max_i(ns_to_cycles(T_CYC_NS, CLK_KHZ), N_SU + N_HI + N_HOLD);
    localparam int CW     = $clog2(N_TOT + 1);
    localparam logic [CW-1:0] C_RISE = CW'(N_SU);
    localparam logic [CW-1:0] C_FALL = CW'(N_SU + N_HI);
    localparam logic [CW-1:0] C_SAMP = CW'(N_SU + N_HI - 1);
    localparam logic [CW-1:0] C_LAST = CW'(N_TOT - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          rs_q, rw_q;
    logic [7:0]    dq;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            rs_q   <= 1'b0;
            rw_q   <= 1'b0;
            dq     <= 8'h00;
            rdata  <= 8'h00;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                rs_q   <= req.rs;
                rw_q   <= req.rw;
                dq     <= req.rw ? 8'h00 : req.data;
            end
        end else begin
            if (cnt == C_LAST) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (cnt == C_SAMP) begin
                rdata <= db_i;
            end
        end
    end

    assign lcd_e  = active && (cnt >= C_RISE) && (cnt < C_FALL);
    assign done   = active && (cnt == C_LAST);
    assign lcd_rs = rs_q;
    assign lcd_rw = rw_q;
    assign db_o   = dq;
    assign db_oe  = active && !rw_q;

endmodule

// File: rtl/lcd_pbus_lane.sv
module lcd_pbus_lane (
    input  logic       nibble_mode,
    input  logic       second,
    input  logic [7:0] wbyte,
    input  logic [3:0] hi_nib,
    input  logic [7:0] rdata,
    output logic [7:0] bus_out,
    output logic [7:0] byte_in,
    output logic       last
);
    always_comb begin
        if (!nibble_mode) begin
            bus_out = wbyte;
            byte_in = rdata;
            last    = 1'b1;
        end else begin
            bus_out = second ? {wbyte[3:0], 4'h0} : {wbyte[7:4], 4'h0};
            byte_in = {hi_nib, rdata[7:4]};
            last    = second;
        end
    end
endmodule

// File: rtl/lcd_pbus_seq.sv
module lcd_pbus_seq
    import lcd_pbus_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nibble_mode,
    input  logic [LIMIT_W-1:0] poll_limit,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  lcd_req_t           cmd,
    output logic               go,
    output lcd_req_t           req,
    input  logic               done,
    input  logic [7:0]         rdata,
    output logic               rsp_valid,
    output logic [7:0]         rsp_data,
    output logic [6:0]         rsp_addr,
    output logic               poll_err
);
    seq_state_e         state;
    lcd_req_t           cmd_q;
    logic               half;
    logic [3:0]         hi_q;
    logic [6:0]         ac_q;
    logic [LIMIT_W-1:0] busy_cnt;
    logic [7:0]         bus_out, byte_in;
    logic               last;

    lcd_pbus_lane u_lane (
        .nibble_mode (nibble_mode),
        .second      (half),
        .wbyte       (cmd_q.data),
        .hi_nib      (hi_q),
        .rdata       (rdata),
        .bus_out     (bus_out),
        .byte_in     (byte_in),
        .last        (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cmd_q     <= '0;
            half      <= 1'b0;
            hi_q      <= 4'h0;
            ac_q      <= 7'h00;
            busy_cnt  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= 8'h00;
            rsp_addr  <= 7'h00;
            poll_err  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            poll_err  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q    <= cmd;
                        half     <= 1'b0;
                        busy_cnt <= '0;
                        state    <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (done) begin
                        if (!last) begin
                            half <= 1'b1;
                            hi_q <= rdata[7:4];
                        end else begin
                            half <= 1'b0;
                            if (byte_in[7]) begin
                                if (busy_cnt >= poll_limit) begin
                                    poll_err <= 1'b1;
                                    state    <= SQ_IDLE;
                                end else begin
                                    busy_cnt <= busy_cnt + 1'b1;
                                end
                            end else begin
                                ac_q  <= byte_in[6:0];
                                state <= SQ_XFER;
                            end
                        end
                    end
                end
                SQ_XFER: begin
                    if (done) begin
                        if (!last) begin
                            half <= 1'b1;
                            hi_q <= rdata[7:4];
                        end else begin
                            half  <= 1'b0;
                            state <= SQ_IDLE;
                            if (cmd_q.rw) begin
                                rsp_valid <= 1'b1;
                                rsp_data  <= byte_in;
                                rsp_addr  <= ac_q;
                            end
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == SQ_IDLE);
    assign go        = (state != SQ_IDLE);

    always_comb begin
        if (state == SQ_XFER) begin
            req.rs   = cmd_q.rs;
            req.rw   = cmd_q.rw;
            req.data = bus_out;
        end else begin
            req.rs   = 1'b0;
            req.rw   = 1'b1;
            req.data = 8'h00;
        end
    end

endmodule

// File: rtl/lcd_pbus_master.sv
module lcd_pbus_master
    import lcd_pbus_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int T_CYC_NS  = 1200,
    parameter int T_PW_NS   = 140,
    parameter int T_SU_NS   = 10,
    parameter int T_HOLD_NS = 20,
    parameter int T_DSW_NS  = 40,
    parameter int T_DDR_NS  = 100,
    parameter int LIMIT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nibble_mode,
    input  logic [LIMIT_W-1:0] poll_limit,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_rs,
    input  logic               cmd_rw,
    input  logic [7:0]         cmd_wdata,
    output logic               rsp_valid,
    output logic [7:0]         rsp_data,
    output logic [6:0]         rsp_addr,
    output logic               poll_err,
    output logic               lcd_rs,
    output logic               lcd_rw,
    output logic               lcd_e,
    output logic [7:0]         db_o,
    output logic               db_oe,
    input  logic [7:0]         db_i
);
    lcd_req_t   cmd_in;
    lcd_req_t   stb_req;
    logic       stb_go;
    logic       stb_done;
    logic [7:0] stb_rdata;

    assign cmd_in = '{rs: cmd_rs, rw: cmd_rw, data: cmd_wdata};

    lcd_pbus_seq #(
        .LIMIT_W (LIMIT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .nibble_mode (nibble_mode),
        .poll_limit  (poll_limit),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd         (cmd_in),
        .go          (stb_go),
        .req         (stb_req),
        .done        (stb_done),
        .rdata       (stb_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_addr    (rsp_addr),
        .poll_err    (poll_err)
    );

    lcd_pbus_strobe #(
        .CLK_KHZ   (CLK_KHZ),
        .T_CYC_NS  (T_CYC_NS),
        .T_PW_NS   (T_PW_NS),
        .T_SU_NS   (T_SU_NS),
        .T_HOLD_NS (T_HOLD_NS),
        .T_DSW_NS  (T_DSW_NS),
        .T_DDR_NS  (T_DDR_NS)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .go     (stb_go),
        .req    (stb_req),
        .done   (stb_done),
        .rdata  (stb_rdata),
        .lcd_rs (lcd_rs),
        .lcd_rw (lcd_rw),
        .lcd_e  (lcd_e),
        .db_o   (db_o),
        .db_oe  (db_oe),
        .db_i   (db_i)
    );

endmodule

// File: rtl/lcd_pbus_checker.sv
module lcd_pbus_checker
    import lcd_pbus_pkg::*;
#(
    parameter int CLK_KHZ  = 50000,
    parameter int T_PW_NS  = 140,
    parameter int T_SU_NS  = 10,
    parameter int T_DSW_NS = 40,
    parameter int T_DDR_NS = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       nibble_mode,
    input logic       cmd_ready,
    input logic       rsp_valid,
    input logic       poll_err,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] db_o,
    input logic       db_oe
);
    localparam int N_SU = max_i(1, ns_to_cycles(T_SU_NS, CLK_KHZ));
    localparam int N_HI = strobe_hi_cycles(T_PW_NS, T_DDR_NS, T_DSW_NS, N_SU, CLK_KHZ);

    int hi_run;
    always_ff @(posedge clk) begin
        if (rst) hi_run <= 0;
        else     hi_run <= lcd_e ? hi_run + 1 : 0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!lcd_e && !db_oe && !rsp_valid && !poll_err));

    assert_nibble_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (nibble_mode && db_oe) |-> (db_o[3:0] == 4'h0));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !db_oe);

    assert_enable_width_R7: assert property (@(posedge clk) disable iff (rst)
        hi_run <= N_HI);

    assert_select_stable_high_R7: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(db_oe)));

    assert_select_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    assert_rsp_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cmd_ready);

    assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_valid, poll_err}));

    assert_err_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        poll_err |-> cmd_ready);

    assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !lcd_e);

endmodule

bind lcd_pbus_master lcd_pbus_checker #(
    .CLK_KHZ  (CLK_KHZ),
    .T_PW_NS  (T_PW_NS),
    .T_SU_NS  (T_SU_NS),
    .T_DSW_NS (T_DSW_NS),
    .T_DDR_NS (T_DDR_NS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nibble_mode (nibble_mode),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .poll_err    (poll_err),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_e       (lcd_e),
    .db_o        (db_o),
    .db_oe       (db_oe)
);

// File: tb/test_lcd_pbus_master.sv
module test_lcd_pbus_master;

    localparam int EXP_HI     = 7;   // max(140ns, 100ns+1cyc, 40ns-1cyc) at 20 ns
    localparam int EXP_PERIOD = 60;  // 1200 ns at 20 ns

    logic        clk = 1'b0;
    logic        rst;
    logic        nibble_mode;
    logic [15:0] poll_limit;
    logic        cmd_valid, cmd_rs, cmd_rw;
    logic [7:0]  cmd_wdata;
    logic        cmd_ready, rsp_valid, poll_err;
    logic [7:0]  rsp_data;
    logic [6:0]  rsp_addr;
    logic        lcd_rs, lcd_rw, lcd_e, db_oe;
    logic [7:0]  db_o;
    logic [7:0]  db_i;

    always #10 clk = ~clk;

    lcd_pbus_master i_lcd_pbus_master (
        .clk(clk), .rst(rst), .nibble_mode(nibble_mode), .poll_limit(poll_limit),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rs(cmd_rs), .cmd_rw(cmd_rw),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_addr(rsp_addr), .poll_err(poll_err), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e(lcd_e), .db_o(db_o), .db_oe(db_oe), .db_i(db_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural controller model and bus monitor
    int          busy_left;
    logic [6:0]  m_ac;
    logic [7:0]  m_rd;
    logic        m_phase;
    logic [10:0] obs_q[$];
    logic        rsp_seen, err_seen;
    logic [7:0]  rsp_d;
    logic [6:0]  rsp_a;
    logic        e_p, rs_p, rw_p, oe_p;
    logic [7:0]  dbo_p;
    int          hi_cnt, since_rise;
    logic        seen_rise;

    always @(negedge clk) begin
        logic [7:0] full;
        if (rst) begin
            e_p = 0; rs_p = 0; rw_p = 0; oe_p = 0; dbo_p = 0;
            hi_cnt = 0; since_rise = 0; seen_rise = 0; m_phase = 0; db_i = 8'h00;
        end else begin
            if (lcd_rw && db_oe) chk(0, "R6", "drive during read", 1, 0);
            if (lcd_e && !e_p) begin
                obs_q.push_back({lcd_rs, lcd_rw, db_oe, db_oe ? db_o : 8'h00});
                if (seen_rise)
                    chk(since_rise >= EXP_PERIOD, "R7", "rise spacing", since_rise, EXP_PERIOD);
                seen_rise  = 1;
                since_rise = 0;
                full = lcd_rs ? m_rd : {busy_left != 0, m_ac};
                if (nibble_mode)
                    db_i = m_phase ? {full[3:0], 4'h5} : {full[7:4], 4'hA};
                else
                    db_i = full;
            end
            if (lcd_e || e_p)
                chk((lcd_rs === rs_p) && (lcd_rw === rw_p) && (db_oe === oe_p) &&
                    (!db_oe || db_o === dbo_p), "R7", "select/data stability",
                    {lcd_rs, lcd_rw, db_oe}, {rs_p, rw_p, oe_p});
            if (!lcd_e && e_p) begin
                chk(hi_cnt == EXP_HI, "R7", "enable high width", hi_cnt, EXP_HI);
                if (lcd_rw && !lcd_rs && (!nibble_mode || m_phase) && busy_left > 0)
                    busy_left--;
                if (nibble_mode) m_phase = ~m_phase;
                db_i = 8'h00;
            end
            hi_cnt = lcd_e ? hi_cnt + 1 : 0;
            since_rise++;
            if (rsp_valid) begin rsp_seen = 1; rsp_d = rsp_data; rsp_a = rsp_addr; end
            if (poll_err) err_seen = 1;
            e_p = lcd_e; rs_p = lcd_rs; rw_p = lcd_rw; oe_p = db_oe; dbo_p = db_o;
        end
    end

    task automatic run_cmd(input logic rs, input logic rw, input logic [7:0] wd,
                           input int busy, input int limit, input bit expect_err,
                           input string tag);
        logic [10:0] exp_q[$];
        int reps, n_stat;
        logic [7:0] exp_byte;
        reps   = nibble_mode ? 2 : 1;
        n_stat = expect_err ? limit + 1 : busy + 1;
        for (int s = 0; s < n_stat; s++)
            for (int h = 0; h < reps; h++) exp_q.push_back({1'b0, 1'b1, 1'b0, 8'h00});
        if (!expect_err) begin
            if (rw) begin
                for (int h = 0; h < reps; h++) exp_q.push_back({rs, 1'b1, 1'b0, 8'h00});
            end else if (nibble_mode) begin
                exp_q.push_back({rs, 1'b0, 1'b1, wd[7:4], 4'h0});
                exp_q.push_back({rs, 1'b0, 1'b1, wd[3:0], 4'h0});
            end else begin
                exp_q.push_back({rs, 1'b0, 1'b1, wd});
            end
        end
        busy_left = busy;
        poll_limit = 16'(limit);
        obs_q.delete();
        rsp_seen = 0; err_seen = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_rs = rs; cmd_rw = rw; cmd_wdata = wd;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        chk(!cmd_ready, "R10", {tag, " ready drops after accept"}, cmd_ready, 0);
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(obs_q.size() == exp_q.size(), (expect_err ? "R9" : "R2"),
            {tag, " strobe count"}, obs_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < obs_q.size(); k++)
            chk(obs_q[k] == exp_q[k], (nibble_mode ? "R5" : "R3"),
                {tag, " strobe content"}, obs_q[k], exp_q[k]);
        chk(err_seen == expect_err, "R9", {tag, " timeout flag"}, err_seen, expect_err);
        if (rw && !expect_err) begin
            exp_byte = rs ? m_rd : {1'b0, m_ac};
            chk(rsp_seen && rsp_d == exp_byte, "R8", {tag, " read byte"}, rsp_d, exp_byte);
            chk(rsp_a == m_ac, "R8", {tag, " address counter"}, rsp_a, m_ac);
        end else begin
            chk(!rsp_seen, "R8", {tag, " no response"}, rsp_seen, 0);
        end
    endtask

    initial begin
        rst = 1; nibble_mode = 0; poll_limit = 16'd8;
        cmd_valid = 0; cmd_rs = 0; cmd_rw = 0; cmd_wdata = 8'h00;
        busy_left = 0; m_ac = 7'h12; m_rd = 8'h3C; rsp_seen = 0; err_seen = 0;
        rsp_d = 0; rsp_a = 0;
        repeat (3) @(negedge clk);
        chk(!lcd_e && !lcd_rs && !lcd_rw && !db_oe && cmd_ready && !rsp_valid && !poll_err,
            "R1", "state in reset", {lcd_e, lcd_rs, lcd_rw, db_oe, cmd_ready}, 5'b00001);
        rst = 0;
        @(negedge clk);
        chk(!lcd_e && !db_oe && cmd_ready && !rsp_valid && !poll_err,
            "R1", "state after reset", {lcd_e, db_oe, cmd_ready}, 3'b001);

        // 8-bit bus
        run_cmd(0, 0, 8'h0C, 0, 8, 0, "R3 R4 instr write");
        run_cmd(1, 0, 8'hA5, 3, 8, 0, "R2 busy data write");
        m_ac = 7'h45; m_rd = 8'h3C;
        run_cmd(1, 1, 8'h00, 1, 8, 0, "R8 data read");
        m_ac = 7'h7F;
        run_cmd(0, 1, 8'h00, 0, 8, 0, "R3 status read");
        run_cmd(1, 0, 8'h81, 10, 2, 1, "R9 timeout");
        run_cmd(0, 0, 8'h01, 2, 2, 0, "R9 limit boundary");
        run_cmd(0, 0, 8'h02, 0, 0, 0, "R9 zero limit idle");

        // 4-bit bus
        nibble_mode = 1;
        run_cmd(0, 0, 8'h96, 1, 8, 0, "R5 nibble instr write");
        m_ac = 7'h2B; m_rd = 8'hE7;
        run_cmd(1, 1, 8'h00, 2, 8, 0, "R5 nibble data read");
        m_ac = 7'h31;
        run_cmd(0, 1, 8'h00, 0, 8, 0, "R5 nibble status read");
        run_cmd(1, 0, 8'h5A, 5, 1, 1, "R9 nibble timeout");
        run_cmd(1, 0, 8'hC3, 0, 8, 0, "R5 nibble data write");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: cycles actual=%0d expected<%0d", 150000, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule